// File: doc/BRIEF.md
# Bus-Error Instruction Restart Controller

This block decides how the core reacts when a bus transfer made on behalf of an instruction ends with an error response. Transient faults on the bus, such as a single-event upset, usually go away when the transfer is repeated. The controller therefore offers one automatic retry for each faulting instruction. On the first error it requests a pipeline flush and a redirect to the faulting program counter. If the same instruction errors again before it retires, the controller escalates to a bus-error exception, and the trap handler takes over.

Software enables the retry feature through a single control bit, written through a small write port. While the bit is clear, every error response becomes an exception at once. The controller keeps one retry flag and the PC it belongs to. The flag is cleared in any of these cases:
- the tracked instruction retires;
- it escalates;
- the feature is switched off.

If a different PC faults, that PC replaces the tracked one.

All outputs are registered. A decision appears on the outputs in the cycle after the error strobe is sampled.

Top module: `restart_ctrl`

## Requirements
- R1: After reset `flush_o`, `exc_o` and `restart_en_o` are 0, `redirect_pc_o` is 0 and no retry is tracked, so the first error after reset raises an exception.
- R2: A cycle with `cfg_we_i`=1 loads `cfg_wdata_i` into the enable bit, which is visible on `restart_en_o` from the next cycle.
- R3: With restart enabled and no matching retry tracked, an error on `err_valid_i` gives, one cycle later, `flush_o`=1 for exactly one cycle, `redirect_pc_o` equal to `err_pc_i` and `exc_o`=0.
- R4: With restart disabled, an error gives `exc_o`=1 one cycle later and no flush.
- R5: A second error from the tracked PC, with no retire in between, gives `exc_o`=1 and no flush. It also clears the tracking, so a third error from that PC flushes again.
- R6: Retirement (`retire_valid_i` with `retire_pc_i` equal to the tracked PC) clears the tracking, so the next error from that PC flushes.
- R7: Retirement of any other PC leaves the tracking intact.
- R8: An error from a PC other than the tracked one flushes to the new PC, and the new PC replaces the tracked one.
- R9: When the tracked PC retires in the same cycle as an error from that PC, the retirement is applied first and the error is treated as a fresh first failure (flush).
- R10: An error in the same cycle as an enable-bit write is judged with the old enable value.
- R11: Writing 0 to the enable bit clears the tracking. After re-enabling, an error from the previously tracked PC flushes.
- R12: `flush_o` and `exc_o` are never 1 in the same cycle, and both drop in the cycle after a cycle with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the restart enable bit |
| cfg_wdata_i | input | 1 | New value of the restart enable bit |
| restart_en_o | output | 1 | Current restart enable bit |
| err_valid_i | input | 1 | Error response seen for an instruction transfer |
| err_pc_i | input | XLEN | PC of the instruction whose transfer failed |
| retire_valid_i | input | 1 | An instruction retired this cycle |
| retire_pc_i | input | XLEN | PC of the retiring instruction |
| flush_o | output | 1 | One-cycle request to flush the pipeline |
| redirect_pc_o | output | XLEN | Restart target, valid with `flush_o`, 0 otherwise |
| exc_o | output | 1 | One-cycle bus-error exception request |

## Verification
Two events can fall in the same cycle: retirement of the tracked instruction and a new error from that same PC. The bench drives both strobes in one cycle and expects a flush rather than an exception, because the retirement is applied first. A second collision is an enable write that coincides with an error. The bench expects the decision that follows from the old enable value. It then reads the tracking state back through the next error's response.

// File: rtl/restart_pkg.sv
package restart_pkg;
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_FLUSH = 2'd1,
        ACT_EXC   = 2'd2
    } act_e;
endpackage

// File: rtl/restart_cfg_reg.sv
module restart_cfg_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic wdata_i,
    output logic en_o,
    output logic clear_o
);
    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (we_i) begin
            en_d = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en_o    = en_q;
    assign clear_o = we_i && !wdata_i;

    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (en_o == $past(wdata_i)));
endmodule

// File: rtl/restart_pc_match.sv
module restart_pc_match #(
    parameter int XLEN  = 32,
    parameter int ALIGN = 1
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            eq_o
);
    generate
        if (ALIGN == 0) begin : g_full
            assign eq_o = (a_i == b_i);
        end else begin : g_aligned
            assign eq_o = (a_i[XLEN-1:ALIGN] == b_i[XLEN-1:ALIGN]);
        end
    endgenerate
endmodule

// File: rtl/restart_decide.sv
module restart_decide
    import restart_pkg::*;
(
    input  logic err_valid_i,
    input  logic en_i,
    input  logic repeat_i,
    output act_e act_o
);
    always_comb begin
        act_o = ACT_NONE;
        if (err_valid_i) begin
            if (!en_i || repeat_i) begin
                act_o = ACT_EXC;
            end else begin
                act_o = ACT_FLUSH;
            end
        end
    end
endmodule

// File: rtl/restart_ctrl.sv
module restart_ctrl
    import restart_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int ALIGN = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we_i,
    input  logic            cfg_wdata_i,
    output logic            restart_en_o,
    input  logic            err_valid_i,
    input  logic [XLEN-1:0] err_pc_i,
    input  logic            retire_valid_i,
    input  logic [XLEN-1:0] retire_pc_i,
    output logic            flush_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            exc_o
);
    typedef struct packed {
        logic            retry;
        logic [XLEN-1:0] retry_pc;
        logic            flush;
        logic [XLEN-1:0] redirect;
        logic            exc;
    } state_t;

    state_t s_d, s_q;
    logic   en_q, cfg_clear;
    logic   ret_eq, err_eq, ret_hit, repeat_hit;
    act_e   act;

    restart_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .en_o    (en_q),
        .clear_o (cfg_clear)
    );

    restart_pc_match #(.XLEN(XLEN), .ALIGN(ALIGN)) u_ret_match (
        .a_i  (retire_pc_i),
        .b_i  (s_q.retry_pc),
        .eq_o (ret_eq)
    );

    restart_pc_match #(.XLEN(XLEN), .ALIGN(ALIGN)) u_err_match (
        .a_i  (err_pc_i),
        .b_i  (s_q.retry_pc),
        .eq_o (err_eq)
    );

    // Retirement is applied before the error is judged.
    assign ret_hit    = retire_valid_i && s_q.retry && ret_eq;
    assign repeat_hit = s_q.retry && !ret_hit && err_eq;

    restart_decide u_decide (
        .err_valid_i (err_valid_i),
        .en_i        (en_q),
        .repeat_i    (repeat_hit),
        .act_o       (act)
    );

    always_comb begin
        s_d          = s_q;
        s_d.flush    = 1'b0;
        s_d.exc      = 1'b0;
        s_d.redirect = '0;
        if (ret_hit) begin
            s_d.retry = 1'b0;
        end
        case (act)
            ACT_FLUSH: begin
                s_d.flush    = 1'b1;
                s_d.redirect = err_pc_i;
                s_d.retry    = 1'b1;
                s_d.retry_pc = err_pc_i;
            end
            ACT_EXC: begin
                s_d.exc   = 1'b1;
                s_d.retry = 1'b0;
            end
            default: ;
        endcase
        if (cfg_clear) begin
            s_d.retry = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign restart_en_o  = en_q;
    assign flush_o       = s_q.flush;
    assign exc_o         = s_q.exc;
    assign redirect_pc_o = s_q.redirect;

    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_o && exc_o));
    p_idle_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid_i |=> (!flush_o && !exc_o));
    p_disabled_exc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid_i && !en_q) |=> (exc_o && !flush_o));
    p_flush_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (redirect_pc_o == s_q.retry_pc));
    p_flush_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(err_valid_i && en_q));
    p_repeat_exc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid_i && s_q.retry && !ret_hit && err_eq) |=> exc_o);
endmodule

// File: tb/tb_restart_ctrl.sv
module tb_restart_ctrl;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we_i = 1'b0, cfg_wdata_i = 1'b0;
    logic            err_valid_i = 1'b0, retire_valid_i = 1'b0;
    logic [XLEN-1:0] err_pc_i = '0, retire_pc_i = '0;
    logic            restart_en_o, flush_o, exc_o;
    logic [XLEN-1:0] redirect_pc_o;
    int              checks = 0, errors = 0;
    bit              done = 1'b0;

    always #5 clk = ~clk;

    restart_ctrl #(.XLEN(XLEN), .ALIGN(1)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we_i       (cfg_we_i),
        .cfg_wdata_i    (cfg_wdata_i),
        .restart_en_o   (restart_en_o),
        .err_valid_i    (err_valid_i),
        .err_pc_i       (err_pc_i),
        .retire_valid_i (retire_valid_i),
        .retire_pc_i    (retire_pc_i),
        .flush_o        (flush_o),
        .redirect_pc_o  (redirect_pc_o),
        .exc_o          (exc_o)
    );

    task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at negedge; sample after the next posedge.
    task automatic step(input bit e, input logic [XLEN-1:0] epc, input bit r,
                        input logic [XLEN-1:0] rpc, input bit we, input bit wd);
        @(negedge clk);
        err_valid_i = e; err_pc_i = epc;
        retire_valid_i = r; retire_pc_i = rpc;
        cfg_we_i = we; cfg_wdata_i = wd;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(0, '0, 0, '0, 0, 0);
    endtask

    task automatic expect_flush(input string req, input logic [XLEN-1:0] pc);
        chk(flush_o === 1'b1, req, {31'b0, flush_o}, 1);
        chk(exc_o === 1'b0, req, {31'b0, exc_o}, 0);
        chk(redirect_pc_o === pc, req, redirect_pc_o, pc);
    endtask

    task automatic expect_exc(input string req);
        chk(exc_o === 1'b1, req, {31'b0, exc_o}, 1);
        chk(flush_o === 1'b0, req, {31'b0, flush_o}, 0);
    endtask

    task automatic set_en(input bit v);
        step(0, '0, 0, '0, 1, v);
        idle();
    endtask

    task automatic t_reset();
        chk(flush_o === 1'b0 && exc_o === 1'b0, "R1 outputs", {30'b0, flush_o, exc_o}, 0);
        chk(restart_en_o === 1'b0, "R1 enable", {31'b0, restart_en_o}, 0);
        chk(redirect_pc_o === '0, "R1 redirect", redirect_pc_o, 0);
        step(1, 32'h100, 0, '0, 0, 0);
        expect_exc("R1 first error");
        idle();
    endtask

    task automatic t_cfg();
        step(0, '0, 0, '0, 1, 1);
        chk(restart_en_o === 1'b1, "R2 set", {31'b0, restart_en_o}, 1);
        idle();
        set_en(0);
        chk(restart_en_o === 1'b0, "R2 clear", {31'b0, restart_en_o}, 0);
    endtask

    task automatic t_disabled();
        step(1, 32'h200, 0, '0, 0, 0);
        expect_exc("R4");
        idle();
        chk(exc_o === 1'b0, "R12 exc drop", {31'b0, exc_o}, 0);
    endtask

    task automatic t_first_and_repeat();
        set_en(1);
        step(1, 32'h300, 0, '0, 0, 0);
        expect_flush("R3", 32'h300);
        idle();
        chk(flush_o === 1'b0 && redirect_pc_o === '0, "R3 one cycle", redirect_pc_o, 0);
        step(1, 32'h300, 0, '0, 0, 0);
        expect_exc("R5 repeat");
        idle();
        step(1, 32'h300, 0, '0, 0, 0);
        expect_flush("R5 third", 32'h300);
        idle();
    endtask

    task automatic t_retire();
        // tracking PC 0x300 from previous task
        step(0, '0, 1, 32'h304, 0, 0);
        step(1, 32'h300, 0, '0, 0, 0);
        expect_exc("R7 other retire");
        idle();
        step(1, 32'h400, 0, '0, 0, 0);
        expect_flush("R6 setup", 32'h400);
        step(0, '0, 1, 32'h400, 0, 0);
        step(1, 32'h400, 0, '0, 0, 0);
        expect_flush("R6 after retire", 32'h400);
        idle();
    endtask

    task automatic t_new_pc();
        // tracking 0x400
        step(1, 32'h500, 0, '0, 0, 0);
        expect_flush("R8 new pc", 32'h500);
        step(1, 32'h500, 0, '0, 0, 0);
        expect_exc("R8 new pc tracked");
        step(1, 32'h400, 0, '0, 0, 0);
        expect_flush("R8 old pc fresh", 32'h400);
        idle();
    endtask

    task automatic t_same_cycle();
        // tracking 0x400
        step(1, 32'h400, 1, 32'h400, 0, 0);
        expect_flush("R9 retire then error", 32'h400);
        step(1, 32'h400, 0, '0, 0, 0);
        expect_exc("R9 tracked again");
        idle();
    endtask

    task automatic t_cfg_race();
        // enabled, nothing tracked; disable in same cycle as error
        step(1, 32'h600, 0, '0, 1, 0);
        expect_flush("R10 old enable", 32'h600);
        chk(restart_en_o === 1'b0, "R10 write taken", {31'b0, restart_en_o}, 0);
        step(1, 32'h700, 0, '0, 1, 1);
        expect_exc("R10 old disable");
        idle();
    endtask

    task automatic t_disable_clears();
        step(1, 32'h800, 0, '0, 0, 0);
        expect_flush("R11 setup", 32'h800);
        set_en(0);
        set_en(1);
        step(1, 32'h800, 0, '0, 0, 0);
        expect_flush("R11 cleared", 32'h800);
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_cfg();
        t_disabled();
        t_first_and_repeat();
        t_retire();
        t_new_pc();
        t_same_cycle();
        t_cfg_race();
        t_disable_clears();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule